// File: doc/BRIEF.md
# Trap Exception Capture Unit

This unit sits next to the decode or execute stage of a pipelined core that issues up to `LANES` instructions per cycle, with lane 0 holding the oldest. Each cycle it examines the valid instruction words. When it finds a system-call or break instruction, it records the exception state for the handler and then asks the front end to restart fetch at the shared exception vector. Neither trap can be masked: if a valid trap instruction reaches the unit while no redirect is pending, the unit takes it.

For each trap the unit records four things: the return address, a 5-bit exception code, a flag that says whether the trapping instruction sat in a branch delay slot, and the 20-bit code field of a break instruction. When the trap sits in a delay slot, the return address points at the branch before it. In the cycle after the capture, the unit raises a one-cycle redirect and a flush, so younger instructions are squashed. Handler software can overwrite the saved return address through a write port, for example to step past the trap before returning.

Top module: `trap_capture`

## Requirements
- R1: After a synchronous reset, `epc_o`, `exc_code_o`, `bd_o`, `brk_code_o`, `redirect_o` and `flush_o` are all zero.
- R2: A valid instruction with bits 31:26 equal to 0 and bits 5:0 equal to 6'h0C is a system call. Taking it sets `exc_code_o` to 8.
- R3: A valid instruction with bits 31:26 equal to 0 and bits 5:0 equal to 6'h0D is a break. Taking it sets `exc_code_o` to 9, and `brk_code_o` takes the instruction's bits 25:6.
- R4: A trap outside a delay slot loads `epc_o` with the instruction's own address and clears `bd_o`.
- R5: A trap inside a delay slot loads `epc_o` with its address minus 4 and sets `bd_o` to 1.
- R6: A system-call trap leaves `brk_code_o` unchanged.
- R7: In the cycle after a trap is taken, `redirect_o` and `flush_o` are high. They stay high for exactly that one cycle, and `redirect_pc_o` equals the `VECTOR` parameter (default 32'h8000_0180).
- R8: When several lanes hold valid traps, only the lowest-indexed one (the oldest) is recorded.
- R9: A trap presented while `redirect_o` is high is ignored. No state changes and no second redirect follows.
- R10: With `epc_wr_en_i` high and no trap taken, `epc_o` takes `epc_wr_data_i` on the next cycle. If a trap is taken in the same cycle, the trap's value wins.
- R11: Invalid lanes and instructions that are not traps change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | LANES | Per-lane instruction valid |
| instr_i | input | LANES x 32 | Per-lane instruction word |
| pc_i | input | LANES x 32 | Per-lane instruction address |
| in_delay_i | input | LANES | Per-lane delay-slot flag |
| epc_wr_en_i | input | 1 | Software write strobe for the return address |
| epc_wr_data_i | input | 32 | Value written to the return address |
| epc_o | output | 32 | Saved return address |
| exc_code_o | output | 5 | Exception code (8 system call, 9 break) |
| bd_o | output | 1 | Delay-slot status bit |
| brk_code_o | output | 20 | Code field of the last break |
| redirect_o | output | 1 | Fetch redirect request |
| redirect_pc_o | output | 32 | Redirect target |
| flush_o | output | 1 | Squash younger instructions |

## Verification
Two activities can fall in the same cycle: a software write of the return address and the capture of a new trap. The bench provokes this by driving `epc_wr_en_i` in the same cycle as a syscall, with different write data. It passes only if `epc_o` ends up holding the trap's address. A second overlap is a trap arriving during the redirect cycle. The bench checks that this trap leaves every recorded field as it was and does not produce a second redirect.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int ADDR_W = 32;
    localparam int INSTR_W = 32;
    localparam int CODE_W = 5;
    localparam int BRK_W = 20;
    localparam logic [5:0] FN_SYS = 6'h0C;
    localparam logic [5:0] FN_BRK = 6'h0D;
    localparam logic [CODE_W-1:0] EXC_SYS = 5'd8;
    localparam logic [CODE_W-1:0] EXC_BRK = 5'd9;

    typedef enum logic [1:0] {TK_NONE, TK_SYS, TK_BRK} trap_kind_e;

    typedef struct packed {
        trap_kind_e          kind;
        logic [ADDR_W-1:0]   ret_pc;
        logic                in_ds;
        logic [BRK_W-1:0]    brk;
    } trap_rec_t;

    function automatic trap_kind_e classify(input logic [INSTR_W-1:0] w);
        if (w[31:26] != 6'd0) return TK_NONE;
        if (w[5:0] == FN_SYS) return TK_SYS;
        if (w[5:0] == FN_BRK) return TK_BRK;
        return TK_NONE;
    endfunction

    function automatic logic is_trap(input logic [INSTR_W-1:0] w);
        return classify(w) != TK_NONE;
    endfunction
endpackage

// File: rtl/trap_decode.sv
module trap_decode
    import trap_pkg::*;
(
    input  logic               valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [ADDR_W-1:0]  pc,
    input  logic               in_delay,
    output trap_rec_t          rec
);
    trap_kind_e kind;

    always_comb begin
        kind       = valid ? classify(instr) : TK_NONE;
        rec.kind   = kind;
        rec.ret_pc = in_delay ? pc - ADDR_W'(4) : pc;
        rec.in_ds  = in_delay;
        rec.brk    = instr[25:6];
    end
endmodule

// File: rtl/trap_select.sv
module trap_select
    import trap_pkg::*;
#(
    parameter int LANES = 2
) (
    input  trap_rec_t recs [LANES],
    output trap_rec_t win,
    output logic      hit
);
    always_comb begin
        win = '0;
        hit = 1'b0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (recs[i].kind != TK_NONE) begin
                win = recs[i];
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/trap_state.sv
module trap_state
    import trap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  trap_rec_t         win,
    input  logic              epc_wr_en,
    input  logic [ADDR_W-1:0] epc_wr_data,
    output logic [ADDR_W-1:0] epc,
    output logic [CODE_W-1:0] exc_code,
    output logic              bd,
    output logic [BRK_W-1:0]  brk_code,
    output logic              redirect
);
    logic take;

    assign take = hit && !redirect;

    always_ff @(posedge clk) begin
        if (rst) begin
            epc      <= '0;
            exc_code <= '0;
            bd       <= 1'b0;
            brk_code <= '0;
            redirect <= 1'b0;
        end else begin
            redirect <= take;
            if (take) begin
                epc      <= win.ret_pc;
                bd       <= win.in_ds;
                exc_code <= (win.kind == TK_SYS) ? EXC_SYS : EXC_BRK;
                if (win.kind == TK_BRK) brk_code <= win.brk;
            end else if (epc_wr_en) begin
                epc <= epc_wr_data;
            end
        end
    end

    // R7
    redir_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        redirect |=> !redirect);

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        redirect |=> ($stable(exc_code) && $stable(bd) && $stable(brk_code)));

    // R2 R3
    code_val_chk: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (exc_code == EXC_SYS || exc_code == EXC_BRK));
endmodule

// File: rtl/trap_capture.sv
module trap_capture
    import trap_pkg::*;
#(
    parameter int              LANES  = 2,
    parameter logic [31:0]     VECTOR = 32'h8000_0180
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [LANES-1:0]              valid_i,
    input  logic [LANES-1:0][INSTR_W-1:0] instr_i,
    input  logic [LANES-1:0][ADDR_W-1:0]  pc_i,
    input  logic [LANES-1:0]              in_delay_i,
    input  logic                          epc_wr_en_i,
    input  logic [ADDR_W-1:0]             epc_wr_data_i,
    output logic [ADDR_W-1:0]             epc_o,
    output logic [CODE_W-1:0]             exc_code_o,
    output logic                          bd_o,
    output logic [BRK_W-1:0]              brk_code_o,
    output logic                          redirect_o,
    output logic [ADDR_W-1:0]             redirect_pc_o,
    output logic                          flush_o
);
    trap_rec_t recs [LANES];
    trap_rec_t win;
    logic      hit;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        trap_decode u_dec (
            .valid    (valid_i[g]),
            .instr    (instr_i[g]),
            .pc       (pc_i[g]),
            .in_delay (in_delay_i[g]),
            .rec      (recs[g])
        );
    end

    trap_select #(.LANES(LANES)) u_sel (
        .recs (recs),
        .win  (win),
        .hit  (hit)
    );

    trap_state u_st (
        .clk         (clk),
        .rst         (rst),
        .hit         (hit),
        .win         (win),
        .epc_wr_en   (epc_wr_en_i),
        .epc_wr_data (epc_wr_data_i),
        .epc         (epc_o),
        .exc_code    (exc_code_o),
        .bd          (bd_o),
        .brk_code    (brk_code_o),
        .redirect    (redirect_o)
    );

    assign flush_o       = redirect_o;
    assign redirect_pc_o = VECTOR;

    // R4 R5 R8
    oldest_epc_chk: assert property (@(posedge clk) disable iff (rst)
        (!redirect_o && valid_i[0] && is_trap(instr_i[0])) |=>
        (epc_o == ($past(in_delay_i[0]) ? $past(pc_i[0]) - 32'd4 : $past(pc_i[0]))
         && bd_o == $past(in_delay_i[0])));

    // R7
    redir_after_chk: assert property (@(posedge clk) disable iff (rst)
        (!redirect_o && |(valid_i & {LANES{1'b1}}) && (valid_i[0] && is_trap(instr_i[0])))
        |=> redirect_o);

    // R10
    epc_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (epc_wr_en_i && redirect_o) |=> epc_o == $past(epc_wr_data_i));
endmodule

// File: tb/trap_capture_bench.sv
module trap_capture_bench;
    localparam int LANES = 2;
    localparam logic [31:0] VEC = 32'h8000_0180;

    logic clk = 1'b0;
    logic rst;
    logic [LANES-1:0]        valid_i;
    logic [LANES-1:0][31:0]  instr_i;
    logic [LANES-1:0][31:0]  pc_i;
    logic [LANES-1:0]        in_delay_i;
    logic                    epc_wr_en_i;
    logic [31:0]             epc_wr_data_i;
    logic [31:0]             epc_o;
    logic [4:0]              exc_code_o;
    logic                    bd_o;
    logic [19:0]             brk_code_o;
    logic                    redirect_o;
    logic [31:0]             redirect_pc_o;
    logic                    flush_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    trap_capture #(.LANES(LANES), .VECTOR(VEC)) u_trap_capture (
        .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i), .pc_i(pc_i),
        .in_delay_i(in_delay_i), .epc_wr_en_i(epc_wr_en_i), .epc_wr_data_i(epc_wr_data_i),
        .epc_o(epc_o), .exc_code_o(exc_code_o), .bd_o(bd_o), .brk_code_o(brk_code_o),
        .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o), .flush_o(flush_o)
    );

    function automatic logic [31:0] sys_w(input logic [19:0] c);
        return {6'd0, c, 6'h0C};
    endfunction
    function automatic logic [31:0] brk_w(input logic [19:0] c);
        return {6'd0, c, 6'h0D};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        valid_i = '0; instr_i = '0; pc_i = '0; in_delay_i = '0;
        epc_wr_en_i = 1'b0; epc_wr_data_i = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put(input int l, input logic [31:0] w, input logic [31:0] a, input logic ds);
        valid_i[l] = 1'b1; instr_i[l] = w; pc_i[l] = a; in_delay_i[l] = ds;
    endtask

    task automatic t_reset();
        idle(); rst = 1'b1;
        step(); step();
        rst = 1'b0;
        chk("R1 epc", epc_o, 0);
        chk("R1 code", {27'd0, exc_code_o}, 0);
        chk("R1 bd", {31'd0, bd_o}, 0);
        chk("R1 brk", {12'd0, brk_code_o}, 0);
        chk("R1 redirect", {30'd0, redirect_o, flush_o}, 0);
    endtask

    task automatic t_syscall();
        put(0, sys_w(20'h1234), 32'h0000_1000, 1'b0);
        step(); idle();
        chk("R2 code", {27'd0, exc_code_o}, 8);
        chk("R4 epc", epc_o, 32'h0000_1000);
        chk("R4 bd", {31'd0, bd_o}, 0);
        chk("R6 brk unchanged", {12'd0, brk_code_o}, 0);
        chk("R7 redirect+flush", {30'd0, redirect_o, flush_o}, 3);
        chk("R7 vector", redirect_pc_o, VEC);
        step();
        chk("R7 one cycle", {30'd0, redirect_o, flush_o}, 0);
    endtask

    task automatic t_break_ds();
        put(0, brk_w(20'hABCDE), 32'h0000_2008, 1'b1);
        step(); idle();
        chk("R3 code", {27'd0, exc_code_o}, 9);
        chk("R3 brk field", {12'd0, brk_code_o}, 32'h000A_BCDE);
        chk("R5 epc", epc_o, 32'h0000_2004);
        chk("R5 bd", {31'd0, bd_o}, 1);
        step();
    endtask

    task automatic t_syscall_ds();
        put(0, sys_w(20'h00001), 32'h0000_3010, 1'b1);
        step(); idle();
        chk("R5 sys epc", epc_o, 32'h0000_300C);
        chk("R6 brk kept", {12'd0, brk_code_o}, 32'h000A_BCDE);
        step();
        put(0, sys_w(20'h0), 32'h0000_3100, 1'b0);
        step(); idle();
        chk("R4 bd cleared", {31'd0, bd_o}, 0);
        step();
    endtask

    task automatic t_lanes();
        put(0, sys_w(20'h1), 32'h0000_4000, 1'b0);
        put(1, brk_w(20'h7), 32'h0000_4004, 1'b0);
        step(); idle();
        chk("R8 oldest code", {27'd0, exc_code_o}, 8);
        chk("R8 oldest epc", epc_o, 32'h0000_4000);
        step();
        put(1, brk_w(20'h55), 32'h0000_5004, 1'b1);
        step(); idle();
        chk("R8 lane1 code", {27'd0, exc_code_o}, 9);
        chk("R8 lane1 epc", epc_o, 32'h0000_5000);
        step();
    endtask

    task automatic t_pending();
        put(0, sys_w(20'h0), 32'h0000_6000, 1'b0);
        step(); idle();
        put(0, brk_w(20'hFFFFF), 32'h0000_6104, 1'b1);
        step(); idle();
        chk("R9 epc kept", epc_o, 32'h0000_6000);
        chk("R9 code kept", {27'd0, exc_code_o}, 8);
        chk("R9 brk kept", {12'd0, brk_code_o}, 32'h55);
        chk("R9 no redirect", {31'd0, redirect_o}, 0);
        step();
        chk("R9 still none", {31'd0, redirect_o}, 0);
    endtask

    task automatic t_epc_write();
        epc_wr_en_i = 1'b1; epc_wr_data_i = 32'h0000_6004;
        step(); idle();
        chk("R10 write", epc_o, 32'h0000_6004);
        put(0, sys_w(20'h0), 32'h0000_7000, 1'b0);
        epc_wr_en_i = 1'b1; epc_wr_data_i = 32'hDEAD_0000;
        step(); idle();
        chk("R10 trap wins", epc_o, 32'h0000_7000);
        step();
    endtask

    task automatic t_nontrap();
        put(0, 32'h0400_000C, 32'h0000_8000, 1'b1);
        put(1, 32'h0000_000E, 32'h0000_8004, 1'b0);
        step();
        valid_i = '0; instr_i[0] = brk_w(20'h3); instr_i[1] = sys_w(20'h3);
        step(); idle();
        chk("R11 epc", epc_o, 32'h0000_7000);
        chk("R11 code", {27'd0, exc_code_o}, 8);
        chk("R11 redirect", {31'd0, redirect_o}, 0);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(); rst = 1'b1;
        @(negedge clk);
        t_reset();
        t_syscall();
        t_break_ds();
        t_syscall_ds();
        t_lanes();
        t_pending();
        t_epc_write();
        t_nontrap();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule